// File: doc/BRIEF.md
# Serial Video Fill-Character Remover

This block sits behind the character aligners of a three-lane serial video receiver. Each lane (red, green, blue) delivers one 10-bit character per asserted `char_en`. When the link clock runs at twice or four times the pixel rate, the transmitter pads every pixel with fixed fill characters. This block strips that padding and hands one character per lane to the downstream decoder, together with a single strobe per pixel slot.

The slot phase is not known after reset. The block locks on the first pixel character that follows blanking. After that it re-locks at every blanking exit, and a new rate ratio is taken up at that point only. Lanes may lag one another by up to one character. The lag pattern is measured at each blanking exit, and the early lanes are delayed to match.

While locked, every character is checked against its slot position. A misplaced fill character, or a missing fill character, sets a sticky error flag.

Top module: `fill_strip`

## Requirements
- R1: After reset `pix_valid` and `stuff_err` are 0. Until the first re-lock, no strobe is produced and no stuffing error is flagged, whatever characters arrive.
- R2: The fill code is 10'b0001111010 (bit 9 written leftmost). The control codes are 10'b1101010100, 10'b0010101011, 10'b0101010100 and 10'b1010101011. Any other value is an active character.
- R3: `ratio_sel` 2'b00 gives a slot of 1 character, 2'b01 gives 2, and 2'b10 or 2'b11 gives 4. The slot's first character is data and the rest are fill. For each slot, `pix_valid` pulses for one clock, in the cycle after the clock edge that takes the slot's data character. All three lane outputs are updated in that same cycle, and each carries its lane's data character.
- R4: Once a lane run with no active character and at least one control character has been seen, the first character where any lane is active starts a new slot at position 0. That character is data. The lock is kept from then on.
- R5: `ratio_sel` is sampled only at a re-lock. A change made at any other time has no effect on slot length or checking until the next re-lock.
- R6: While locked, a fill on any lane at a data position, or a non-fill on any lane at a fill position, sets `stuff_err`.
- R7: `stuff_err` stays set until `err_clr` is high for a clock edge, which clears it. A new error in the same cycle wins over the clear.
- R8: A lane may lag the others by one character. Lanes that turn active one character before the rest at a blanking exit are delayed by one character until the next exit. The output is then as if the lanes had no skew.
- R9: Clock edges with `char_en` low neither advance the slot nor produce a strobe. The lane inputs are ignored on those edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_en | input | 1 | One character per lane is present this edge |
| ratio_sel | input | 2 | Link-clock to pixel-rate ratio (00 1x, 01 2x, 1x 4x) |
| err_clr | input | 1 | Clears the stuffing error flag |
| lane_r | input | 10 | Red lane character |
| lane_g | input | 10 | Green lane character |
| lane_b | input | 10 | Blue lane character |
| pix_r | output | 10 | Red data character of the last slot |
| pix_g | output | 10 | Green data character of the last slot |
| pix_b | output | 10 | Blue data character of the last slot |
| pix_valid | output | 1 | One-clock strobe per slot |
| stuff_err | output | 1 | Sticky stuffing-error flag |

## Verification
The block has no parameters, so the bench builds it in its one fixed form. Coverage comes from the inputs it drives instead: every `ratio_sel` value including 2'b11, and a ratio change made while the old ratio is still running through blanking. It also runs three lane-lag patterns (none, green late, red and blue late) and a segment with an idle clock between characters. These reach the deskew selection at a 2x, a 4x and a 1x blanking exit. They also cover the case where the first blanking after reset is seen with the lanes misaligned.

// File: rtl/fill_strip.sv
module fill_strip (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       char_en,
  input  logic [1:0] ratio_sel,
  input  logic       err_clr,
  input  logic [9:0] lane_r,
  input  logic [9:0] lane_g,
  input  logic [9:0] lane_b,
  output logic [9:0] pix_r,
  output logic [9:0] pix_g,
  output logic [9:0] pix_b,
  output logic       pix_valid,
  output logic       stuff_err
);
  localparam int LN = 3;
  localparam int CW = 10;
  localparam logic [CW-1:0] FILL = 10'b0001111010;
  localparam logic [CW-1:0] K0 = 10'b1101010100;
  localparam logic [CW-1:0] K1 = 10'b0010101011;
  localparam logic [CW-1:0] K2 = 10'b0101010100;
  localparam logic [CW-1:0] K3 = 10'b1010101011;

  function automatic logic is_k(input logic [CW-1:0] c);
    return (c == K0) || (c == K1) || (c == K2) || (c == K3);
  endfunction

  function automatic logic [1:0] slot_last(input logic [1:0] m);
    case (m)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

  logic [CW-1:0] raw [LN];
  logic [CW-1:0] dly [LN];
  logic [CW-1:0] al  [LN];
  logic [LN-1:0] r_k, r_act, a_k, a_fill, a_act;
  logic [LN-1:0] sel_q, sel_new, sel;
  logic          raw_arm, al_arm, lock_q, trig, realign, live, bad;
  logic [1:0]    pos_q, pos, ratio_q, ratio_eff;

  assign raw[0] = lane_r;
  assign raw[1] = lane_g;
  assign raw[2] = lane_b;

  always_comb begin
    for (int i = 0; i < LN; i++) begin
      r_k[i]   = is_k(raw[i]);
      r_act[i] = !r_k[i] && (raw[i] != FILL);
    end
  end

  assign trig    = raw_arm && |r_act;
  assign sel_new = r_act & {LN{~&r_act}};
  assign sel     = trig ? sel_new : sel_q;

  always_comb begin
    for (int i = 0; i < LN; i++) begin
      al[i]     = sel[i] ? dly[i] : raw[i];
      a_k[i]    = is_k(al[i]);
      a_fill[i] = (al[i] == FILL);
      a_act[i]  = !a_k[i] && !a_fill[i];
    end
  end

  assign realign   = al_arm && |a_act;
  assign pos       = realign ? 2'd0 : pos_q;
  assign ratio_eff = realign ? ratio_sel : ratio_q;
  assign live      = lock_q || realign;
  assign bad       = (pos == 2'd0) ? |a_fill : ~&a_fill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LN; i++) dly[i] <= '0;
      sel_q   <= '0;
      raw_arm <= 1'b0;
      al_arm  <= 1'b0;
      lock_q  <= 1'b0;
      pos_q   <= 2'd0;
      ratio_q <= 2'd0;
    end else if (char_en) begin
      for (int i = 0; i < LN; i++) dly[i] <= raw[i];
      sel_q <= sel;
      if (trig)                     raw_arm <= 1'b0;
      else if (!(|r_act) && |r_k)   raw_arm <= 1'b1;
      if (realign)                  al_arm <= 1'b0;
      else if (!(|a_act) && |a_k)   al_arm <= 1'b1;
      lock_q  <= live;
      ratio_q <= ratio_eff;
      pos_q   <= (pos == slot_last(ratio_eff)) ? 2'd0 : pos + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      pix_r     <= '0;
      pix_g     <= '0;
      pix_b     <= '0;
    end else begin
      pix_valid <= char_en && live && (pos == 2'd0);
      if (char_en && live && (pos == 2'd0)) begin
        pix_r <= al[0];
        pix_g <= al[1];
        pix_b <= al[2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        stuff_err <= 1'b0;
    else if (char_en && live && bad)   stuff_err <= 1'b1;
    else if (err_clr)                  stuff_err <= 1'b0;
  end
endmodule

module fill_strip_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       char_en,
  input logic       err_clr,
  input logic       pix_valid,
  input logic       stuff_err,
  input logic       lock_q,
  input logic       realign,
  input logic [1:0] ratio_q
);
  AST_STROBE_ON_CHAR: assert property (@(posedge clk) disable iff (!rst_n) pix_valid |-> $past(char_en)); // R9
  AST_NO_EARLY_STROBE: assert property (@(posedge clk) disable iff (!rst_n) (!lock_q && !realign) |=> !pix_valid); // R1
  AST_LOCK_KEPT: assert property (@(posedge clk) disable iff (!rst_n) lock_q |=> lock_q); // R4
  AST_RATIO_HELD: assert property (@(posedge clk) disable iff (!rst_n) !realign |=> $stable(ratio_q)); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (stuff_err && !err_clr) |=> stuff_err); // R7
  AST_ERR_NEEDS_CHAR: assert property (@(posedge clk) disable iff (!rst_n) (!stuff_err && !char_en) |=> !stuff_err); // R6
endmodule

bind fill_strip fill_strip_chk u_chk (
  .clk(clk), .rst_n(rst_n), .char_en(char_en), .err_clr(err_clr),
  .pix_valid(pix_valid), .stuff_err(stuff_err), .lock_q(lock_q),
  .realign(realign), .ratio_q(ratio_q)
);

// File: tb/fill_strip_test.sv
module fill_strip_test;
  localparam logic [9:0] FILL = 10'b0001111010;
  localparam logic [9:0] K0 = 10'b1101010100;
  localparam logic [9:0] K1 = 10'b0010101011;
  localparam logic [9:0] K2 = 10'b0101010100;
  localparam logic [9:0] K3 = 10'b1010101011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic char_en = 1'b0;
  logic [1:0] ratio_sel = 2'b10;
  logic err_clr = 1'b0;
  logic [9:0] lane_r = '0, lane_g = '0, lane_b = '0;
  logic [9:0] pix_r, pix_g, pix_b;
  logic pix_valid, stuff_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [29:0] exp_q [$];
  logic [9:0] prv [3];
  logic [2:0] skew = 3'b000;
  bit gap = 0;
  logic [1:0] cur_ratio = 2'b10;
  bit blk_lock = 0;
  int base = 0;

  always #4 clk = ~clk;

  fill_strip uut (
    .clk(clk), .rst_n(rst_n), .char_en(char_en), .ratio_sel(ratio_sel),
    .err_clr(err_clr), .lane_r(lane_r), .lane_g(lane_g), .lane_b(lane_b),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .pix_valid(pix_valid),
    .stuff_err(stuff_err)
  );

  function automatic logic [9:0] pv(input int k, input int ln);
    return {2'b11, 7'(k * 13 + ln * 41 + 3), 1'b1};
  endfunction

  function automatic logic [9:0] kcode(input int n);
    case (n % 4)
      0: return K0;
      1: return K1;
      2: return K2;
      default: return K3;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && pix_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R1 R3 unexpected strobe actual=%0h expected=none", {pix_r, pix_g, pix_b});
      end else begin
        logic [29:0] e;
        e = exp_q.pop_front();
        if ({pix_r, pix_g, pix_b} !== e) begin
          n_bad++;
          $display("FAIL R2 R3 R8 pixel actual=%0h expected=%0h", {pix_r, pix_g, pix_b}, e);
        end
      end
    end
  end

  task automatic put(input logic [9:0] r, input logic [9:0] g, input logic [9:0] b);
    logic [9:0] c [3];
    c[0] = r; c[1] = g; c[2] = b;
    @(negedge clk);
    lane_r  <= skew[0] ? prv[0] : c[0];
    lane_g  <= skew[1] ? prv[1] : c[1];
    lane_b  <= skew[2] ? prv[2] : c[2];
    char_en <= 1'b1;
    for (int i = 0; i < 3; i++) prv[i] = c[i];
    if (gap) begin
      @(negedge clk);
      char_en <= 1'b0;
      lane_r <= FILL; lane_g <= pv(999, 1); lane_b <= K1;   // R9 junk
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      char_en <= 1'b0;
    end
  endtask

  task automatic slot(input logic [9:0] r, input logic [9:0] g, input logic [9:0] b,
                      input bit push, input bit bad_fill);
    int nf;
    nf = (cur_ratio == 2'b00) ? 0 : (cur_ratio == 2'b01) ? 1 : 3;
    if (push) exp_q.push_back({r, g, b});
    put(r, g, b);
    for (int f = 0; f < nf; f++)
      put((bad_fill && f == 0) ? pv(777, 0) : FILL, FILL, FILL);
  endtask

  task automatic line(input logic [1:0] nr, input int nb, input int np);
    ratio_sel <= nr;                       // R5: taken only at next re-lock
    for (int b = 0; b < nb; b++) slot(K0, K0, kcode(b), blk_lock, 0);
    cur_ratio = nr;
    blk_lock = 1;
    for (int p = 0; p < np; p++) slot(pv(base + p, 0), pv(base + p, 1), pv(base + p, 2), 1, 0);
    base += np;
  endtask

  task automatic finish_seg(input string tag);
    if (skew != 3'b000) put(K0, K0, K0);
    idle(6);
    check({tag, " R3 all slots delivered"}, exp_q.size(), 0);
  endtask

  task automatic do_reset(input logic [2:0] sk, input bit gp, input logic [1:0] rt);
    @(negedge clk);
    rst_n <= 1'b0; char_en <= 1'b0; err_clr <= 1'b0; ratio_sel <= rt;
    skew = sk; gap = gp; cur_ratio = rt; blk_lock = 0;
    for (int i = 0; i < 3; i++) prv[i] = K0;
    exp_q.delete();
    repeat (3) @(negedge clk);
    check("R1 pix_valid in reset", pix_valid, 0);
    check("R1 stuff_err in reset", stuff_err, 0);
    rst_n <= 1'b1;
    @(negedge clk);
  endtask

  task automatic clear_err();
    @(negedge clk);
    char_en <= 1'b0; err_clr <= 1'b1;
    @(negedge clk);
    err_clr <= 1'b0;
    @(negedge clk);
  endtask

  initial begin
    // segment 1: no skew, all ratios, deferred ratio change
    do_reset(3'b000, 0, 2'b10);
    for (int k = 0; k < 9; k++) put(pv(500 + k, 0), (k % 3 == 0) ? FILL : pv(500 + k, 1), pv(500 + k, 2));
    idle(2);
    check("R1 no error before lock", stuff_err, 0);
    line(2'b10, 4, 6);
    line(2'b10, 3, 5);
    idle(2); check("R4 R6 clean 4x lines", stuff_err, 0);
    line(2'b00, 3, 7);
    idle(2); check("R5 4x to 1x change", stuff_err, 0);
    line(2'b01, 3, 6);
    idle(2); check("R5 1x to 2x change", stuff_err, 0);
    line(2'b11, 3, 5);
    line(2'b01, 2, 4);
    idle(2); check("R3 ratio 11 as 4x", stuff_err, 0);
    finish_seg("seg1");

    // segment 2: stuffing errors, sticky flag and clear
    do_reset(3'b000, 0, 2'b10);
    line(2'b10, 3, 4);
    slot(pv(60, 0), FILL, pv(60, 2), 1, 0);
    idle(1); check("R6 fill at data position", stuff_err, 1);
    slot(pv(61, 0), pv(61, 1), pv(61, 2), 1, 0);
    idle(1); check("R7 flag held", stuff_err, 1);
    clear_err(); check("R7 flag cleared", stuff_err, 0);
    slot(pv(62, 0), pv(62, 1), pv(62, 2), 1, 1);
    idle(1); check("R6 active at fill position", stuff_err, 1);
    clear_err(); check("R7 flag cleared again", stuff_err, 0);
    line(2'b00, 3, 3);
    idle(1); check("R5 no false error after switch", stuff_err, 0);
    slot(pv(63, 0), pv(63, 1), FILL, 1, 0);
    idle(1); check("R6 fill at 1x data position", stuff_err, 1);
    finish_seg("seg2");

    // segment 3: green lane late
    do_reset(3'b010, 0, 2'b01);
    line(2'b01, 4, 6);
    line(2'b01, 3, 5);
    line(2'b00, 3, 6);
    idle(1); check("R8 green late no error", stuff_err, 0);
    finish_seg("seg3 R8");

    // segment 4: red and blue late, gaps between characters
    do_reset(3'b101, 1, 2'b10);
    line(2'b10, 3, 5);
    line(2'b00, 3, 6);
    line(2'b01, 2, 4);
    idle(1); check("R8 R9 red blue late with gaps", stuff_err, 0);
    finish_seg("seg4 R9");

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule